// File: doc/BRIEF.md
# Chip-Select External Bus Cycle Controller

This block turns one internal access request into an external bus cycle aimed at a chip-selected memory region. The request carries an address, a read/write flag and write data. It arrives with the match results from the on-chip RAM, the two system bus regions, every chip-select region and every DRAM region. A fixed priority over those matches picks where the access goes. Only a chip-select access runs a cycle on the external pins. On-chip, system-bus and DRAM targets are only reported back with a route code. A combination the priority does not cover ends at once in an error.

A chip-select cycle has three phases. The first clock drives the address. The chip select goes low at the falling edge in the middle of that clock. Zero to fifteen wait clocks follow, set per region by a 4-bit field. The data clock comes next, and it ends with an internally generated transfer acknowledge. A final hold clock keeps the address and write data on the pins. Read data is captured at the rising edge that closes the data clock and is returned with the response. No new request is taken until the hold clock is over.

Top module: `csbus_ctrl`

## Requirements
- R1: `req_ready` is high whenever no cycle is in progress, and that includes right after reset. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. The match inputs are only looked at on that edge.
- R2: The route code is chosen by priority. An on-chip match gives 0. Otherwise a system region 2 match gives 1, then a system region 1 match gives 2. Exactly one chip-select match with no DRAM match gives 3. Exactly one DRAM match with no chip-select match gives 4. Every other case gives 5.
- R3: For route codes 0, 1, 2, 4 and 5, the response appears in the clock right after acceptance. `rsp_err` is high only for code 5. No chip select, output enable or write-data drive is asserted.
- R4: A chip-select access keeps `req_ready` low for n+3 clocks. Here n is the 4-bit wait field of the matched region i, taken from `cs_wait[4i+3:4i]`.
- R5: Only the chip-select line of the matched region goes low. It stays high in the first half of the address clock and goes low at the falling edge in its middle.
- R6: The chip select stays low through the wait clocks and the data clock. It returns high at the rising edge that ends the data clock, which gives n+1.5 clocks of low time.
- R7: `bus_ta` is high for exactly one clock, the data clock. For a cycle accepted at edge k, that is the clock that begins at edge k+n+1.
- R8: A read captures `bus_rdata` at the rising edge that ends the data clock. It returns that value on `rsp_rdata`, with `rsp_valid` high, route 3 and no error, during the hold clock.
- R9: `bus_oe_n` is low only while the chip select is low during a read.
- R10: On a write, `bus_wdata_oe` is high from the edge that ends the address clock to the edge that ends the hold clock. During that time `bus_wdata` holds the request data. A read never raises `bus_wdata_oe`.
- R11: `bus_addr` equals the request address from the address clock through the hold clock.
- R12: The response to a chip-select write has `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| hit_onchip | input | 1 | On-chip RAM match |
| hit_sys2 | input | 1 | System bus region 2 match |
| hit_sys1 | input | 1 | System bus region 1 match |
| cs_hits | input | NCS | Per chip-select region match |
| dram_hits | input | NDRAM | Per DRAM region match |
| cs_wait | input | NCS*WSW | Wait-state field per chip-select region |
| req_ready | output | 1 | Controller free to take a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Access terminated in error |
| rsp_route | output | 3 | Route code of the access |
| rsp_rdata | output | DW | Read data |
| bus_addr | output | AW | External address |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_wdata | output | DW | External write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_ta | output | 1 | Internal transfer acknowledge |
| bus_rdata | input | DW | External read data |

## Verification
The bench sends chip-select reads and writes to regions whose wait fields are 0, 1, 3 and 15. These show whether the wait count comes from the right field, and how it stretches the chip-select low time and the busy time. For every cycle, the bench samples the pins in both halves of each clock. This is what separates a chip select asserted at the falling edge from one asserted at the rising edge, and a release at the end of the data clock from one at the end of the hold clock. Match patterns with several hits at once test each step of the priority. Patterns with no hit, two chip-select hits, two DRAM hits, or a chip-select hit together with a DRAM hit must all end in an error with no pin activity.

// File: rtl/csbus_pkg.sv
package csbus_pkg;

    typedef enum logic [2:0] {
        RT_ONCHIP  = 3'd0,
        RT_SYS2    = 3'd1,
        RT_SYS1    = 3'd2,
        RT_CHIPSEL = 3'd3,
        RT_DRAM    = 3'd4,
        RT_UNDEF   = 3'd5
    } route_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WAIT,
        PH_DATA,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic   valid;
        logic   err;
        route_e route;
    } rsp_stat_t;

    // Fixed-priority target choice from reduced match information
    function automatic route_e pick_route(
        input logic onchip,
        input logic sys2,
        input logic sys1,
        input logic cs_one,
        input logic cs_none,
        input logic dram_one,
        input logic dram_none
    );
        if (onchip)                      return RT_ONCHIP;
        else if (sys2)                   return RT_SYS2;
        else if (sys1)                   return RT_SYS1;
        else if (cs_one && dram_none)    return RT_CHIPSEL;
        else if (dram_one && cs_none)    return RT_DRAM;
        else                             return RT_UNDEF;
    endfunction

    function automatic logic cs_active(input phase_e ph, input logic fell);
        return (ph == PH_ADDR && fell) || ph == PH_WAIT || ph == PH_DATA;
    endfunction

endpackage

// File: rtl/csbus_route.sv
module csbus_route
    import csbus_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int NDRAM = 2,
    parameter int WSW   = 4
) (
    input  logic                 hit_onchip,
    input  logic                 hit_sys2,
    input  logic                 hit_sys1,
    input  logic [NCS-1:0]       cs_hits,
    input  logic [NDRAM-1:0]     dram_hits,
    input  logic [NCS*WSW-1:0]   cs_wait,
    output route_e               route,
    output logic [WSW-1:0]       wait_n
);

    logic [WSW-1:0] masked [NCS];
    int cs_cnt;
    int dram_cnt;

    genvar g;
    generate
        for (g = 0; g < NCS; g++) begin : g_field
            assign masked[g] = cs_hits[g] ? cs_wait[g*WSW +: WSW] : '0;
        end
    endgenerate

    always_comb begin
        wait_n = '0;
        for (int i = 0; i < NCS; i++) begin
            wait_n = wait_n | masked[i];
        end
    end

    always_comb begin
        cs_cnt   = $countones(cs_hits);
        dram_cnt = $countones(dram_hits);
    end

    assign route = pick_route(hit_onchip, hit_sys2, hit_sys1,
                              cs_cnt == 1, cs_cnt == 0,
                              dram_cnt == 1, dram_cnt == 0);

endmodule

// File: rtl/csbus_seq.sv
module csbus_seq
    import csbus_pkg::*;
#(
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [WSW-1:0] wait_n,
    output phase_e         phase
);

    phase_e         phase_q;
    logic [WSW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_ADDR;
                        cnt_q   <= wait_n;
                    end
                end
                PH_ADDR, PH_WAIT: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_DATA;
                    end else begin
                        phase_q <= PH_WAIT;
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                PH_DATA: phase_q <= PH_HOLD;
                PH_HOLD: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/csbus_pads.sv
module csbus_pads
    import csbus_pkg::*;
#(
    parameter int NCS = 4,
    parameter int AW  = 16,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  phase_e         phase,
    input  logic           lat_write,
    input  logic [AW-1:0]  lat_addr,
    input  logic [DW-1:0]  lat_wdata,
    input  logic [NCS-1:0] lat_sel,
    output logic [AW-1:0]  bus_addr,
    output logic [NCS-1:0] bus_cs_n,
    output logic           bus_oe_n,
    output logic [DW-1:0]  bus_wdata,
    output logic           bus_wdata_oe,
    output logic           bus_ta
);

    logic fell_q;
    logic cs_on;

    // Half-clock marker: set at the falling edge inside the address clock
    always_ff @(negedge clk) begin
        if (rst) fell_q <= 1'b0;
        else     fell_q <= (phase == PH_ADDR);
    end

    assign cs_on        = cs_active(phase, fell_q);
    assign bus_cs_n     = ~(lat_sel & {NCS{cs_on}});
    assign bus_oe_n     = ~(cs_on & ~lat_write);
    assign bus_wdata_oe = lat_write &&
                          (phase == PH_WAIT || phase == PH_DATA || phase == PH_HOLD);
    assign bus_wdata    = bus_wdata_oe ? lat_wdata : '0;
    assign bus_addr     = lat_addr;
    assign bus_ta       = (phase == PH_DATA);

endmodule

// File: rtl/csbus_ctrl.sv
module csbus_ctrl
    import csbus_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int NCS   = 4,
    parameter int NDRAM = 2,
    parameter int WSW   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic               hit_onchip,
    input  logic               hit_sys2,
    input  logic               hit_sys1,
    input  logic [NCS-1:0]     cs_hits,
    input  logic [NDRAM-1:0]   dram_hits,
    input  logic [NCS*WSW-1:0] cs_wait,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [2:0]         rsp_route,
    output logic [DW-1:0]      rsp_rdata,
    output logic [AW-1:0]      bus_addr,
    output logic [NCS-1:0]     bus_cs_n,
    output logic               bus_oe_n,
    output logic [DW-1:0]      bus_wdata,
    output logic               bus_wdata_oe,
    output logic               bus_ta,
    input  logic [DW-1:0]      bus_rdata
);

    route_e         route;
    logic [WSW-1:0] wait_n;
    phase_e         phase;
    logic           accept;
    logic           start;

    logic           lat_write;
    logic [AW-1:0]  lat_addr;
    logic [DW-1:0]  lat_wdata;
    logic [NCS-1:0] lat_sel;

    rsp_stat_t      stat_q;
    logic [DW-1:0]  rdata_q;

    csbus_route #(.NCS(NCS), .NDRAM(NDRAM), .WSW(WSW)) u_route (
        .hit_onchip (hit_onchip),
        .hit_sys2   (hit_sys2),
        .hit_sys1   (hit_sys1),
        .cs_hits    (cs_hits),
        .dram_hits  (dram_hits),
        .cs_wait    (cs_wait),
        .route      (route),
        .wait_n     (wait_n)
    );

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign start     = accept && (route == RT_CHIPSEL);

    csbus_seq #(.WSW(WSW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .wait_n (wait_n),
        .phase  (phase)
    );

    // Request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_sel   <= '0;
        end else if (start) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_sel   <= cs_hits;
        end
    end

    // Response generation
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '{valid: 1'b0, err: 1'b0, route: RT_ONCHIP};
            rdata_q <= '0;
        end else if (accept && route != RT_CHIPSEL) begin
            stat_q  <= '{valid: 1'b1, err: (route == RT_UNDEF), route: route};
            rdata_q <= '0;
        end else if (phase == PH_DATA) begin
            stat_q  <= '{valid: 1'b1, err: 1'b0, route: RT_CHIPSEL};
            rdata_q <= lat_write ? '0 : bus_rdata;
        end else begin
            stat_q.valid <= 1'b0;
        end
    end

    assign rsp_valid = stat_q.valid;
    assign rsp_err   = stat_q.err;
    assign rsp_route = stat_q.route;
    assign rsp_rdata = rdata_q;

    csbus_pads #(.NCS(NCS), .AW(AW), .DW(DW)) u_pads (
        .clk          (clk),
        .rst          (rst),
        .phase        (phase),
        .lat_write    (lat_write),
        .lat_addr     (lat_addr),
        .lat_wdata    (lat_wdata),
        .lat_sel      (lat_sel),
        .bus_addr     (bus_addr),
        .bus_cs_n     (bus_cs_n),
        .bus_oe_n     (bus_oe_n),
        .bus_wdata    (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe),
        .bus_ta       (bus_ta)
    );

endmodule

// File: rtl/csbus_ctrl_chk.sv
module csbus_ctrl_chk #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           rsp_err,
    input logic [2:0]     rsp_route,
    input logic [AW-1:0]  bus_addr,
    input logic [NCS-1:0] bus_cs_n,
    input logic           bus_oe_n,
    input logic [DW-1:0]  bus_wdata,
    input logic           bus_wdata_oe,
    input logic           bus_ta
);

    assert_other_route_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route != 3'd3) |-> (&bus_cs_n));

    assert_err_only_undef_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err == (rsp_route == 3'd5)));

    assert_free_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == 3'd3) |=> req_ready);

    assert_single_select_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(~bus_cs_n) <= 1);

    assert_release_after_data_R6: assert property (@(posedge clk) disable iff (rst)
        bus_ta |=> (&bus_cs_n));

    assert_ta_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        bus_ta |=> !bus_ta);

    assert_rsp_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        bus_ta |=> (rsp_valid && rsp_route == 3'd3 && !rsp_err));

    assert_oe_not_on_write_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_n |-> !bus_wdata_oe);

    assert_wdata_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wdata_oe && $past(bus_wdata_oe)) |-> $stable(bus_wdata));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        bus_ta |=> $stable(bus_addr));

endmodule

bind csbus_ctrl csbus_ctrl_chk #(.AW(AW), .DW(DW), .NCS(NCS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_route    (rsp_route),
    .bus_addr     (bus_addr),
    .bus_cs_n     (bus_cs_n),
    .bus_oe_n     (bus_oe_n),
    .bus_wdata    (bus_wdata),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_ta       (bus_ta)
);

// File: tb/csbus_ctrl_test.sv
`timescale 1ns/1ps
module csbus_ctrl_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NCS = 4;
    localparam int NDRAM = 2;
    localparam int WSW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic hit_onchip = 1'b0, hit_sys2 = 1'b0, hit_sys1 = 1'b0;
    logic [NCS-1:0] cs_hits = '0;
    logic [NDRAM-1:0] dram_hits = '0;
    logic [NCS*WSW-1:0] cs_wait = {4'd15, 4'd3, 4'd1, 4'd0};
    logic req_ready, rsp_valid, rsp_err;
    logic [2:0] rsp_route;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [NCS-1:0] bus_cs_n;
    logic bus_oe_n, bus_wdata_oe, bus_ta;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    always #4 clk = ~clk;

    // External device: returns a pattern derived from the address while enabled
    assign bus_rdata = bus_oe_n ? '0 : (bus_addr ^ 16'hA5C3);

    csbus_ctrl uut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0]    route;
        logic          err;
        logic [DW-1:0] rdata;
        string         req;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each response against the scoreboard head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_route == e.route, "R2", "route code", rsp_route, e.route);
                    chk(rsp_err == e.err, "R3", "error flag", rsp_err, e.err);
                    chk(rsp_rdata == e.rdata, e.req, "response data", rsp_rdata, e.rdata);
                end
            end
        end
    end

    // Driver: called at 6 ns past a rising edge with req_ready high
    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic oc, input logic s2, input logic s1,
                         input logic [NCS-1:0] csh, input logic [NDRAM-1:0] dh,
                         input logic [2:0] exp_route, input int n);
        exp_t e;
        int idx = 0;
        int busy = 0, early_low = 0, late_low = 0, other_low = 0;
        int ta_cnt = 0, ta_pos = -1, oe_cnt = 0, wde_cnt = 0, wd_bad = 0, addr_bad = 0;
        bit first_early_hi = 1'b0, first_late_lo = 1'b0;
        bit ready_e;
        bit is_cs = (exp_route == 3'd3);
        for (int i = 0; i < NCS; i++) if (csh[i]) idx = i;
        e.route = exp_route;
        e.err   = (exp_route == 3'd5);
        e.rdata = (is_cs && !wr) ? (a ^ 16'hA5C3) : '0;
        e.req   = (is_cs && !wr) ? "R8" : (is_cs ? "R12" : "R3");
        sb.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        hit_onchip = oc; hit_sys2 = s2; hit_sys1 = s1; cs_hits = csh; dram_hits = dh;
        @(posedge clk);
        #1;
        req_valid = 1'b0; hit_onchip = 1'b0; hit_sys2 = 1'b0; hit_sys1 = 1'b0;
        cs_hits = '0; dram_hits = '0; req_addr = ~a; req_wdata = ~wd;
        forever begin
            ready_e = req_ready;
            if (!ready_e) begin
                if (busy == 0 && bus_cs_n[idx]) first_early_hi = 1'b1;
                if (!bus_cs_n[idx]) early_low++;
                if (bus_ta) begin ta_cnt++; ta_pos = busy; end
                if (bus_wdata_oe) begin
                    wde_cnt++;
                    if (bus_wdata != wd) wd_bad++;
                end
                if (bus_addr != a) addr_bad++;
            end
            for (int i = 0; i < NCS; i++) if (i != idx && !bus_cs_n[i]) other_low++;
            if (!is_cs && (!bus_cs_n[idx] || bus_wdata_oe || !bus_oe_n)) other_low++;
            #4;
            if (busy == 0 && !ready_e && !bus_cs_n[idx]) first_late_lo = 1'b1;
            if (!bus_cs_n[idx]) late_low++;
            if (!bus_oe_n) oe_cnt++;
            for (int i = 0; i < NCS; i++) if (i != idx && !bus_cs_n[i]) other_low++;
            if (!is_cs && (!bus_cs_n[idx] || bus_wdata_oe || !bus_oe_n)) other_low++;
            if (ready_e) break;
            busy++;
            @(posedge clk);
            #1;
        end
        #1;
        if (!is_cs) begin
            chk(busy == 0, "R3", "busy clocks", busy, 0);
            chk(other_low == 0, "R3", "pin activity", other_low, 0);
        end else begin
            chk(busy == n + 3, "R4", "busy clocks", busy, n + 3);
            chk(first_early_hi && first_late_lo, "R5", "select at falling edge",
                {first_early_hi, first_late_lo}, 3);
            chk(other_low == 0, "R5", "wrong select line", other_low, 0);
            chk(early_low == n + 1, "R6", "select low, first halves", early_low, n + 1);
            chk(late_low == n + 2, "R6", "select low, second halves", late_low, n + 2);
            chk(ta_cnt == 1 && ta_pos == n + 1, "R7", "acknowledge position", ta_pos, n + 1);
            chk(oe_cnt == (wr ? 0 : n + 2), "R9", "output enable halves", oe_cnt, wr ? 0 : n + 2);
            chk(wde_cnt == (wr ? n + 2 : 0), "R10", "write drive clocks", wde_cnt, wr ? n + 2 : 0);
            chk(wd_bad == 0, "R10", "write data value", wd_bad, 0);
            chk(addr_bad == 0, "R11", "address hold", addr_bad, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #6 rst = 1'b0;
        @(posedge clk);
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(bus_cs_n == '1 && bus_oe_n && !bus_wdata_oe && !bus_ta && !rsp_valid,
            "R1", "idle pins after reset", bus_cs_n, 15);
        #5;
        // chip-select reads and writes over every wait setting
        issue(1'b0, 16'h1234, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0001, 2'b00, 3'd3, 0);
        issue(1'b1, 16'h2222, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4'b0001, 2'b00, 3'd3, 0);
        issue(1'b0, 16'h0F0F, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0010, 2'b00, 3'd3, 1);
        issue(1'b1, 16'h4444, 16'h1357, 1'b0, 1'b0, 1'b0, 4'b0100, 2'b00, 3'd3, 3);
        issue(1'b0, 16'hFFFE, 16'h0, 1'b0, 1'b0, 1'b0, 4'b1000, 2'b00, 3'd3, 15);
        issue(1'b1, 16'h8001, 16'hA0A0, 1'b0, 1'b0, 1'b0, 4'b1000, 2'b00, 3'd3, 15);
        // priority ladder
        issue(1'b0, 16'h0100, 16'h0, 1'b1, 1'b1, 1'b1, 4'b0001, 2'b01, 3'd0, 0);
        issue(1'b0, 16'h0200, 16'h0, 1'b0, 1'b1, 1'b1, 4'b0001, 2'b00, 3'd1, 0);
        issue(1'b1, 16'h0300, 16'h5, 1'b0, 1'b0, 1'b1, 4'b0011, 2'b11, 3'd2, 0);
        issue(1'b0, 16'h0400, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 2'b10, 3'd4, 0);
        // undefined combinations
        issue(1'b0, 16'h0500, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 2'b00, 3'd5, 0);
        issue(1'b1, 16'h0600, 16'h7, 1'b0, 1'b0, 1'b0, 4'b0101, 2'b00, 3'd5, 0);
        issue(1'b0, 16'h0700, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0100, 2'b01, 3'd5, 0);
        issue(1'b0, 16'h0800, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 2'b11, 3'd5, 0);
        // a chip-select cycle right after a routed-away access
        issue(1'b0, 16'h3C3C, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0100, 2'b00, 3'd3, 3);
        repeat (3) @(posedge clk);
        #1;
        chk(sb.size() == 0, "R1", "responses outstanding", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule